// File: doc/BRIEF.md
# Radio Configuration and Channel Sequencer

This block steps a packet radio through its power-up setup and later retunes it while it is running, with no reset in between. It does not talk to the radio itself. It hands one command at a time to a serial framer, which turns each command into a bus transaction. A command is either a one-byte strobe, where the address is the opcode, or a 16-bit register write. The framer reports that it is working on a command by holding `fr_busy_i` high.

A `start_i` pulse runs the setup script. The script switches the crystal oscillator on and waits a set number of cycles for it to settle. It then writes the modem, frequency and I/O configuration registers and ends by switching the receiver on. After setup, a channel-change pulse switches the RF off, rewrites the frequency register for the new channel and switches the receiver back on. A flush pulse empties the radio's receive FIFO. A change or flush that arrives while a script is running is held and served once the running script completes. Every completed script raises `done_o` for one cycle.

Top module: `radio_seq`

## Requirements
- R1: After reset, `fr_req_o`, `done_o` and `configured_o` are all low.
- R2: A `start_i` pulse issues, in this order: strobe 0x01, writes to registers 0x11, 0x18 and 0x1C, then strobe 0x03. `done_o` then pulses once and `configured_o` is set. `fr_write_o` is 1 for a register write and 0 for a strobe, and a strobe carries its opcode on `fr_addr_o`.
- R3: At least OSC_WAIT cycles pass between the oscillator strobe and the first register write request.
- R4: The write to 0x11 carries MODEM_DEFAULT with bit 11 cleared, which turns automatic address filtering off.
- R5: Every write to 0x18 carries FREQ_DEFAULT in bits 15:10 and FREQ_BASE + 5 × channel in bits 9:0. The channel is 4 bits wide, giving 16 channels.
- R6: The write to 0x1C carries RX_THRESH in bits 6:0 and IOCFG_DEFAULT in the other bits. The default threshold is 64.
- R7: Once the block is configured, a channel change issues strobe 0x06, then a write to 0x18 for the new channel, then strobe 0x03, then pulses `done_o`. `configured_o` stays high throughout.
- R8: Once the block is configured, a flush request issues strobe 0x08 and then pulses `done_o`.
- R9: A request is a one-cycle pulse issued only while `fr_busy_i` is low. The next request waits until busy has risen and then fallen again.
- R10: A change or flush requested during a running script, or before setup has finished, is held and served afterwards. A pending change is served before a pending flush, and the channel index from the latest change request is the one used.
- R11: A `start_i` pulse that arrives while a script is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Runs the setup script |
| chan_i | input | CHAN_W | Channel index, sampled on start or change request |
| chg_req_i | input | 1 | Channel change request |
| flush_req_i | input | 1 | Receive FIFO flush request |
| fr_busy_i | input | 1 | Framer is busy with a command |
| fr_req_o | output | 1 | Command request pulse |
| fr_write_o | output | 1 | 1 = register write, 0 = strobe |
| fr_addr_o | output | 6 | Register address or strobe opcode |
| fr_data_o | output | 16 | Register write data |
| configured_o | output | 1 | Setup script has completed |
| done_o | output | 1 | One-cycle pulse when a script ends |

## Verification
The assertions rely on the framer behaving well. They assume it raises busy within a few cycles of accepting a request and always drops it again. Without that, the single-outstanding-request property and the oscillator gap counter say nothing. The bench's framer model raises busy on the clock edge that accepts a request, holds it for three cycles and then releases it. Requests, start and channel inputs are driven at the falling edge as single-cycle pulses, so each one meets exactly one rising edge.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
  typedef enum logic [1:0] {OP_STROBE, OP_WRITE, OP_WAIT, OP_END} op_kind_e;
  typedef enum logic [1:0] {SEQ_INIT, SEQ_CHAN, SEQ_FLUSH} seq_e;
  typedef struct packed {
    op_kind_e    kind;
    logic [5:0]  addr;
    logic [15:0] data;
  } op_t;

  localparam logic [5:0] STB_NOP      = 6'h00;
  localparam logic [5:0] STB_OSC_ON   = 6'h01;
  localparam logic [5:0] STB_RX_ON    = 6'h03;
  localparam logic [5:0] STB_TX_ON    = 6'h04;
  localparam logic [5:0] STB_RF_OFF   = 6'h06;
  localparam logic [5:0] STB_FLUSH_RX = 6'h08;
  localparam logic [5:0] REG_MODEM    = 6'h11;
  localparam logic [5:0] REG_FREQ     = 6'h18;
  localparam logic [5:0] REG_IOCFG    = 6'h1C;
  localparam int unsigned STEP_W      = 3;
endpackage

// File: rtl/radio_seq_script.sv
module radio_seq_script
  import radio_seq_pkg::*;
#(
  parameter int unsigned CHAN_W        = 4,
  parameter int unsigned FREQ_BASE     = 357,
  parameter logic [15:0] MODEM_DEFAULT = 16'h0AE2,
  parameter logic [15:0] FREQ_DEFAULT  = 16'h4000,
  parameter logic [15:0] IOCFG_DEFAULT = 16'h0000,
  parameter int unsigned RX_THRESH     = 64
) (
  input  seq_e              seq_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [CHAN_W-1:0] chan_i,
  output op_t               op_o
);
  logic [9:0]  freq_field;
  logic [15:0] modem_word, freq_word, iocfg_word;

  assign freq_field = 10'(FREQ_BASE) + 10'(chan_i) * 10'd5;
  assign modem_word = MODEM_DEFAULT & ~16'h0800;
  assign freq_word  = {FREQ_DEFAULT[15:10], freq_field};
  assign iocfg_word = {IOCFG_DEFAULT[15:7], 7'(RX_THRESH)};

  always_comb begin
    op_o = '{kind: OP_END, addr: STB_NOP, data: 16'h0000};
    unique case (seq_i)
      SEQ_INIT: begin
        case (step_i)
          3'd0: op_o = '{OP_STROBE, STB_OSC_ON, 16'h0000};
          3'd1: op_o = '{OP_WAIT, STB_NOP, 16'h0000};
          3'd2: op_o = '{OP_WRITE, REG_MODEM, modem_word};
          3'd3: op_o = '{OP_WRITE, REG_FREQ, freq_word};
          3'd4: op_o = '{OP_WRITE, REG_IOCFG, iocfg_word};
          3'd5: op_o = '{OP_STROBE, STB_RX_ON, 16'h0000};
          default: ;
        endcase
      end
      SEQ_CHAN: begin
        case (step_i)
          3'd0: op_o = '{OP_STROBE, STB_RF_OFF, 16'h0000};
          3'd1: op_o = '{OP_WRITE, REG_FREQ, freq_word};
          3'd2: op_o = '{OP_STROBE, STB_RX_ON, 16'h0000};
          default: ;
        endcase
      end
      SEQ_FLUSH: begin
        if (step_i == 3'd0) op_o = '{OP_STROBE, STB_FLUSH_RX, 16'h0000};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/radio_seq_pending.sv
module radio_seq_pending #(
  parameter int unsigned CHAN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chg_req_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              flush_req_i,
  input  logic              take_chg_i,
  input  logic              take_flush_i,
  output logic              chg_pend_o,
  output logic [CHAN_W-1:0] chan_pend_o,
  output logic              flush_pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_pend_o   <= 1'b0;
      chan_pend_o  <= '0;
      flush_pend_o <= 1'b0;
    end else begin
      // a fresh request in the take cycle stays pending
      if (chg_req_i) begin
        chg_pend_o  <= 1'b1;
        chan_pend_o <= chan_i;
      end else if (take_chg_i) begin
        chg_pend_o <= 1'b0;
      end
      if (flush_req_i)       flush_pend_o <= 1'b1;
      else if (take_flush_i) flush_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/radio_seq_timer.sv
module radio_seq_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0) && !load_i;
endmodule

// File: rtl/radio_seq.sv
module radio_seq
  import radio_seq_pkg::*;
#(
  parameter int unsigned CHAN_W        = 4,
  parameter int unsigned FREQ_BASE     = 357,
  parameter logic [15:0] MODEM_DEFAULT = 16'h0AE2,
  parameter logic [15:0] FREQ_DEFAULT  = 16'h4000,
  parameter logic [15:0] IOCFG_DEFAULT = 16'h0000,
  parameter int unsigned RX_THRESH     = 64,
  parameter int unsigned OSC_WAIT      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              chg_req_i,
  input  logic              flush_req_i,
  input  logic              fr_busy_i,
  output logic              fr_req_o,
  output logic              fr_write_o,
  output logic [5:0]        fr_addr_o,
  output logic [15:0]       fr_data_o,
  output logic              configured_o,
  output logic              done_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_ACK, ST_FREE, ST_DLY} state_e;

  state_e            state_q;
  seq_e              seq_q;
  logic [STEP_W-1:0] step_q;
  logic [CHAN_W-1:0] chan_q, chan_pend;
  logic              cfg_q, done_q;
  logic              chg_pend, flush_pend, take_chg, take_flush;
  logic              tmr_load, tmr_expired, is_cmd;
  op_t               op;

  radio_seq_script #(
    .CHAN_W(CHAN_W), .FREQ_BASE(FREQ_BASE), .MODEM_DEFAULT(MODEM_DEFAULT),
    .FREQ_DEFAULT(FREQ_DEFAULT), .IOCFG_DEFAULT(IOCFG_DEFAULT), .RX_THRESH(RX_THRESH)
  ) u_script (
    .seq_i(seq_q), .step_i(step_q), .chan_i(chan_q), .op_o(op)
  );

  radio_seq_pending #(.CHAN_W(CHAN_W)) u_pending (
    .clk_i, .rst_ni, .chg_req_i, .chan_i, .flush_req_i,
    .take_chg_i(take_chg), .take_flush_i(take_flush),
    .chg_pend_o(chg_pend), .chan_pend_o(chan_pend), .flush_pend_o(flush_pend)
  );

  radio_seq_timer #(.CYCLES(OSC_WAIT)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .expired_o(tmr_expired)
  );

  // start outranks pending work; change outranks flush
  assign take_chg   = (state_q == ST_IDLE) && !start_i && cfg_q && chg_pend;
  assign take_flush = (state_q == ST_IDLE) && !start_i && cfg_q && !chg_pend && flush_pend;
  assign is_cmd     = (op.kind == OP_STROBE) || (op.kind == OP_WRITE);
  assign tmr_load   = (state_q == ST_RUN) && (op.kind == OP_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seq_q   <= SEQ_INIT;
      step_q  <= '0;
      chan_q  <= '0;
      cfg_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          step_q <= '0;
          if (start_i) begin
            seq_q   <= SEQ_INIT;
            chan_q  <= chan_i;
            cfg_q   <= 1'b0;
            state_q <= ST_RUN;
          end else if (take_chg) begin
            seq_q   <= SEQ_CHAN;
            chan_q  <= chan_pend;
            state_q <= ST_RUN;
          end else if (take_flush) begin
            seq_q   <= SEQ_FLUSH;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (is_cmd) begin
            if (!fr_busy_i) state_q <= ST_ACK;
          end else if (op.kind == OP_WAIT) begin
            state_q <= ST_DLY;
          end else begin
            done_q  <= 1'b1;
            if (seq_q == SEQ_INIT) cfg_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_ACK:  if (fr_busy_i) state_q <= ST_FREE;
        ST_FREE: begin
          if (!fr_busy_i) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_RUN;
          end
        end
        ST_DLY: begin
          if (tmr_expired) begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fr_req_o     = (state_q == ST_RUN) && is_cmd && !fr_busy_i;
  assign fr_write_o   = (op.kind == OP_WRITE);
  assign fr_addr_o    = op.addr;
  assign fr_data_o    = op.data;
  assign configured_o = cfg_q;
  assign done_o       = done_q;
endmodule

// File: rtl/radio_seq_chk.sv
module radio_seq_chk #(
  parameter int unsigned CHAN_W    = 4,
  parameter int unsigned FREQ_BASE = 357,
  parameter int unsigned OSC_WAIT  = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fr_busy_i,
  input logic        fr_req_o,
  input logic        fr_write_o,
  input logic [5:0]  fr_addr_o,
  input logic [15:0] fr_data_o,
  input logic        done_o
);
  localparam int unsigned FREQ_MAX = FREQ_BASE + 5 * ((1 << CHAN_W) - 1);

  logic [15:0] osc_gap;
  logic        out_q, seen_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_gap   <= 16'hFFFF;
      out_q     <= 1'b0;
      seen_busy <= 1'b0;
    end else begin
      if (fr_req_o && !fr_write_o && fr_addr_o == 6'h01) osc_gap <= '0;
      else if (osc_gap != 16'hFFFF)                      osc_gap <= osc_gap + 1'b1;
      if (fr_req_o) begin
        out_q     <= 1'b1;
        seen_busy <= 1'b0;
      end else if (out_q && fr_busy_i) begin
        seen_busy <= 1'b1;
      end else if (seen_busy && !fr_busy_i) begin
        out_q     <= 1'b0;
        seen_busy <= 1'b0;
      end
    end
  end

  AST_REQ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_req_o |-> !fr_busy_i); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_req_o |-> !out_q); // R9
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_req_o |=> !fr_req_o); // R9
  AST_OSC_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_req_o && fr_write_o) |-> (32'(osc_gap) >= OSC_WAIT)); // R3
  AST_ADDR_FILTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_req_o && fr_write_o && fr_addr_o == 6'h11) |-> !fr_data_o[11]); // R4
  AST_FREQ_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_req_o && fr_write_o && fr_addr_o == 6'h18) |->
      (32'(fr_data_o[9:0]) >= FREQ_BASE && 32'(fr_data_o[9:0]) <= FREQ_MAX)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
endmodule

bind radio_seq radio_seq_chk #(
  .CHAN_W(CHAN_W), .FREQ_BASE(FREQ_BASE), .OSC_WAIT(OSC_WAIT)
) u_chk (.*);

// File: tb/radio_seq_bench.sv
module radio_seq_bench;
  localparam int unsigned OSC_WAIT = 16;
  localparam int unsigned BASE     = 357;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, chg = 1'b0, flush = 1'b0, busy = 1'b0;
  logic [3:0]  chan = '0;
  logic        req, wr, cfg, done;
  logic [5:0]  addr;
  logic [15:0] data;

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  int osc_cyc = -1, first_wr_cyc = -1;
  logic [22:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  radio_seq u_radio_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan),
    .chg_req_i(chg), .flush_req_i(flush), .fr_busy_i(busy),
    .fr_req_o(req), .fr_write_o(wr), .fr_addr_o(addr), .fr_data_o(data),
    .configured_o(cfg), .done_o(done)
  );

  function automatic logic [15:0] freq_word(int c);
    return 16'h4000 | 16'(BASE + 5 * c);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic exp_strobe(string tag, logic [5:0] op);
    exp_q.push_back({1'b0, op, 16'h0000});
    tag_q.push_back(tag);
  endtask

  task automatic exp_write(string tag, logic [5:0] a, logic [15:0] d);
    exp_q.push_back({1'b1, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_done(int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && done) done_cnt++;

  // framer model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected request act=%0h exp=none", {wr, addr, data});
        end else begin
          logic [22:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e[22]) check(t, {9'd0, wr, addr, data}, {9'd0, e});
          else       check(t, {25'd0, wr, addr}, {25'd0, e[22:16]});
        end
        if (!wr && addr == 6'h01) osc_cyc = cyc;
        if (wr && first_wr_cyc < 0) first_wr_cyc = cyc;
        @(posedge clk); #1 busy = 1'b1;
        @(negedge clk);
        check("R9 request is one cycle", {31'd0, req}, 32'd0);
        repeat (3) @(posedge clk);
        #1 busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 req after reset", {31'd0, req}, 32'd0);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    check("R1 configured after reset", {31'd0, cfg}, 32'd0);
    rst_n = 1'b1;

    // setup on channel 3, then a held change (latest = 9) and a held flush
    exp_strobe("R2 osc on", 6'h01);
    exp_write("R4 modem reg", 6'h11, 16'h02E2);
    exp_write("R5 freq reg ch3", 6'h18, freq_word(3));
    exp_write("R6 iocfg reg", 6'h1C, 16'h0040);
    exp_strobe("R2 rx on", 6'h03);
    exp_strobe("R10 rf off", 6'h06);
    exp_write("R10 freq reg latest ch9", 6'h18, freq_word(9));
    exp_strobe("R7 rx on", 6'h03);
    exp_strobe("R10 flush after change", 6'h08);

    chan = 4'd3;
    pulse(start);
    repeat (8) @(negedge clk);
    chan = 4'd12;
    pulse(start);            // R11: ignored mid-script
    chan = 4'd7;
    pulse(chg);
    pulse(flush);
    chan = 4'd9;
    pulse(chg);
    wait_done(1);
    @(negedge clk);
    check("R2 configured after setup", {31'd0, cfg}, 32'd1);
    wait_done(3);
    repeat (10) @(negedge clk);
    check("R11 no extra script from late start", done_cnt, 3);
    check("R10 all held work served", exp_q.size(), 0);
    check("R3 osc settle gap", {31'd0, (first_wr_cyc - osc_cyc) >= int'(OSC_WAIT)}, 32'd1);

    // boundary channels
    exp_strobe("R7 rf off", 6'h06);
    exp_write("R5 freq reg ch15", 6'h18, freq_word(15));
    exp_strobe("R7 rx on", 6'h03);
    chan = 4'd15;
    pulse(chg);
    wait_done(4);
    @(negedge clk);
    check("R7 configured kept", {31'd0, cfg}, 32'd1);

    exp_strobe("R7 rf off", 6'h06);
    exp_write("R5 freq reg ch0", 6'h18, freq_word(0));
    exp_strobe("R7 rx on", 6'h03);
    chan = 4'd0;
    pulse(chg);
    wait_done(5);

    exp_strobe("R8 flush", 6'h08);
    pulse(flush);
    wait_done(6);
    repeat (20) @(negedge clk);
    check("R8 done count", done_cnt, 6);
    check("R8 queue drained", exp_q.size(), 0);
    check("R9 idle no request", {31'd0, req}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule